// File: doc/BRIEF.md
# Clock-Synchronized Serial Receiver with Ready Handshake

This block receives 8-bit frames over a clocked serial link, least significant bit first. It can be the clock source (master) or follow a clock from a partner (slave), chosen by `master_i`. As master it produces `sclk_o` from the system clock through a divider. It only starts a new clock pulse while the partner's active-low ready line `rdy_n_i` is low. As slave it takes `sclk_i` and `sdi_i` through two-flop synchronizers and detects edges in the system clock domain. It drives its own active-low ready line `rdy_n_o` high as a busy signal while unread data is held.

Each completed frame moves from the shift register into a receive data register. The same move sets a buffer-full flag and raises a one-cycle interrupt pulse. A read strobe clears the flag. If a frame completes while the flag is still set and no read occurs in that cycle, the new frame overwrites the register and a sticky overrun flag sets. A dedicated strobe clears the overrun flag.

Top module: `sync_serial_rx`

## Requirements
- R1: Frames are 8 bits, received LSB first. A bit is taken from `sdi_i` on each rising edge of the active serial clock (`sclk_o` as master, `sclk_i` as slave). Bit k of `rx_data_o` is the k-th bit received.
- R2: On the eighth rising edge the assembled byte is written to `rx_data_o` and `full_o` goes to 1. `irq_o` is high for exactly that one cycle, in the same cycle `full_o` rises.
- R3: A one-cycle `rd_i` pulse clears `full_o` on the next cycle, unless a frame completes in the same cycle.
- R4: If a frame completes while `full_o` is 1 and `rd_i` is 0, `ovr_o` sets to 1 and the new byte replaces the old one on `rx_data_o`.
- R5: `ovr_o` stays 1 through reads and further frames. Only `ovr_clr_i` or reset clears it.
- R6: In slave mode `rdy_n_o` is 1 while `full_o` is 1 and 0 otherwise. In master mode `rdy_n_o` is 1.
- R7: In master mode `sclk_o` idles high and toggles every `HALF_DIV` system clocks. A falling edge is never started while the synchronized `rdy_n_i` is high, so the clock parks high until ready returns low.
- R8: In slave mode `sclk_o` stays high, and `sclk_i`/`sdi_i` are sampled through two-flop synchronizers before edge detection.
- R9: After reset `full_o`, `ovr_o` and `irq_o` are 0, `rx_data_o` is 0 and `sclk_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_i | input | 1 | 1 = master (generate clock), 0 = slave |
| sclk_i | input | 1 | External serial clock (slave mode) |
| sdi_i | input | 1 | Serial data in |
| rdy_n_i | input | 1 | Partner ready, active low (master mode) |
| rd_i | input | 1 | Read strobe for the data register |
| ovr_clr_i | input | 1 | Clears the overrun flag |
| sclk_o | output | 1 | Generated serial clock (master mode) |
| rdy_n_o | output | 1 | Own ready/busy, active low (slave mode) |
| rx_data_o | output | 8 | Receive data register |
| full_o | output | 1 | Buffer-full flag |
| irq_o | output | 1 | Buffer-full interrupt pulse |
| ovr_o | output | 1 | Sticky overrun flag |

## Verification
A wrong bit counter or shift direction shows at the end of the same frame, as a byte that is rotated or reversed on `rx_data_o`, or as `full_o` rising after the wrong number of clocks. A stuck or mishandled full flag shows within one frame: either as a missing interrupt or as a false overrun. In slave mode it also shows immediately on `rdy_n_o`. A fault in the clock gating appears within one half period as a falling edge of `sclk_o` while ready is held high.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;
  localparam int unsigned FRAME_BITS = 8;
  localparam int unsigned BIT_CNT_W  = $clog2(FRAME_BITS);
  typedef logic [FRAME_BITS-1:0] frame_t;
endpackage

// File: rtl/sync_rx_cdc.sv
module sync_rx_cdc #(
  parameter int unsigned    W       = 1,
  parameter logic [W-1:0]   RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/sync_rx_mclk.sv
module sync_rx_mclk #(
  parameter int unsigned HALF_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic go_i,
  output logic sclk_o,
  output logic rise_o
);
  localparam int unsigned CW = (HALF_DIV < 2) ? 1 : $clog2(HALF_DIV);
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          sclk_q;
  logic          wrap;

  assign wrap   = (cnt_q == LAST);
  assign rise_o = en_i && !sclk_q && wrap;
  assign sclk_o = sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_q <= 1'b1;
    end else if (!en_i) begin
      cnt_q  <= '0;
      sclk_q <= 1'b1;
    end else if (sclk_q && !go_i) begin
      cnt_q  <= '0;               // park high until partner ready
    end else if (wrap) begin
      cnt_q  <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sync_rx_shift.sv
module sync_rx_shift
  import sync_rx_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   restart_i,
  input  logic   rise_i,
  input  logic   bit_i,
  output logic   done_o,
  output frame_t byte_o
);
  localparam logic [BIT_CNT_W-1:0] LAST = BIT_CNT_W'(FRAME_BITS - 1);

  frame_t               sh_q;
  logic [BIT_CNT_W-1:0] cnt_q;

  assign byte_o = {bit_i, sh_q[FRAME_BITS-1:1]};
  assign done_o = rise_i && !restart_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (restart_i) begin
      cnt_q <= '0;
    end else if (rise_i) begin
      sh_q  <= byte_o;
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sync_serial_rx.sv
module sync_serial_rx
  import sync_rx_pkg::*;
#(
  parameter int unsigned HALF_DIV = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  master_i,
  input  logic                  sclk_i,
  input  logic                  sdi_i,
  input  logic                  rdy_n_i,
  input  logic                  rd_i,
  input  logic                  ovr_clr_i,
  output logic                  sclk_o,
  output logic                  rdy_n_o,
  output logic [FRAME_BITS-1:0] rx_data_o,
  output logic                  full_o,
  output logic                  irq_o,
  output logic                  ovr_o
);
  logic [2:0] sync_q;
  logic       rdy_n_s, sclk_s, sdi_s;
  logic       sclk_prev_q, master_q;
  logic       m_rise, s_rise, rise, restart, done;
  frame_t     byte_w, data_q;
  logic       full_q, irq_q, ovr_q;

  sync_rx_cdc #(.W(3), .RST_VAL(3'b111)) u_cdc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({rdy_n_i, sclk_i, sdi_i}),
    .q_o   (sync_q)
  );
  assign {rdy_n_s, sclk_s, sdi_s} = sync_q;

  sync_rx_mclk #(.HALF_DIV(HALF_DIV)) u_mclk (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (master_i),
    .go_i  (!rdy_n_s),
    .sclk_o(sclk_o),
    .rise_o(m_rise)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_prev_q <= 1'b1;
      master_q    <= 1'b0;
    end else begin
      sclk_prev_q <= sclk_s;
      master_q    <= master_i;
    end
  end

  assign s_rise  = !master_i && sclk_s && !sclk_prev_q;
  assign rise    = master_i ? m_rise : s_rise;
  assign restart = (master_i != master_q);

  sync_rx_shift u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(restart),
    .rise_i   (rise),
    .bit_i    (sdi_s),
    .done_o   (done),
    .byte_o   (byte_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      full_q <= 1'b0;
      irq_q  <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      irq_q <= done;
      if (done) begin
        data_q <= byte_w;
        full_q <= 1'b1;
      end else if (rd_i) begin
        full_q <= 1'b0;
      end
      if (done && full_q && !rd_i) ovr_q <= 1'b1;
      else if (ovr_clr_i)          ovr_q <= 1'b0;
    end
  end

  assign rx_data_o = data_q;
  assign full_o    = full_q;
  assign irq_o     = irq_q;
  assign ovr_o     = ovr_q;
  assign rdy_n_o   = master_i ? 1'b1 : full_q;
endmodule

// File: rtl/sync_serial_rx_chk.sv
module sync_serial_rx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic master_i,
  input logic rd_i,
  input logic ovr_clr_i,
  input logic sclk_o,
  input logic full_o,
  input logic irq_o,
  input logic ovr_o
);
  assert_irq_on_fill_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full_o) |-> irq_o);
  assert_irq_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  assert_ovr_needs_full_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_o) |-> ($past(full_o) && irq_o));
  assert_ovr_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_o && !ovr_clr_i) |=> ovr_o);
  assert_read_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && full_o) |=> (!full_o || irq_o));
  assert_slave_clk_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sclk_o) |-> master_i);
endmodule

bind sync_serial_rx sync_serial_rx_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .master_i (master_i),
  .rd_i     (rd_i),
  .ovr_clr_i(ovr_clr_i),
  .sclk_o   (sclk_o),
  .full_o   (full_o),
  .irq_o    (irq_o),
  .ovr_o    (ovr_o)
);

// File: tb/sync_serial_rx_tb.sv
module sync_serial_rx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_DIV   = 6;
  localparam int S_HALF     = 6;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       master_i = 1'b0;
  logic       sclk_i = 1'b1;
  logic       s_sdi = 1'b0;
  logic       m_sdi = 1'b0;
  logic       sdi_i;
  logic       rdy_n_i = 1'b1;
  logic       rd_i = 1'b0;
  logic       ovr_clr_i = 1'b0;
  logic       sclk_o, rdy_n_o, full_o, irq_o, ovr_o;
  logic [7:0] rx_data_o;

  int n_tests = 0;
  int n_fail  = 0;
  int irq_cnt = 0;
  int m_falls = 0;
  int m_idx   = 0;
  int m_k     = 0;
  logic [7:0] m_bytes [8];
  bit finished = 0;

  assign sdi_i = master_i ? m_sdi : s_sdi;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sync_serial_rx #(.HALF_DIV(HALF_DIV)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .master_i(master_i), .sclk_i(sclk_i),
    .sdi_i(sdi_i), .rdy_n_i(rdy_n_i), .rd_i(rd_i), .ovr_clr_i(ovr_clr_i),
    .sclk_o(sclk_o), .rdy_n_o(rdy_n_o), .rx_data_o(rx_data_o),
    .full_o(full_o), .irq_o(irq_o), .ovr_o(ovr_o)
  );

  always @(posedge clk_i) if (irq_o) irq_cnt <= irq_cnt + 1;

  // bench-side partner for master mode: changes data on falling sclk_o
  always @(negedge sclk_o) begin
    m_falls = m_falls + 1;
    m_sdi   = m_bytes[m_k % 8][m_idx];
    m_idx   = m_idx + 1;
    if (m_idx == 8) begin
      m_idx = 0;
      m_k   = m_k + 1;
    end
  end

  function automatic logic [7:0] exp_byte(input logic [7:0] sent);
    return sent;  // LSB-first assembly keeps bit order
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic send_slave(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      sclk_i = 1'b0;
      s_sdi  = b[i];
      clks(S_HALF);
      sclk_i = 1'b1;
      clks(S_HALF);
    end
  endtask

  task automatic do_read();
    rd_i = 1'b1;
    clks(1);
    rd_i = 1'b0;
    clks(1);
  endtask

  task automatic wait_full();
    for (int t = 0; t < 2000; t++) begin
      if (full_o) break;
      clks(1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] b, a;
    int ic;
    void'($urandom(32'h5eed));
    clks(3);
    // R9 reset state
    check("R9 full", full_o, 0);
    check("R9 ovr", ovr_o, 0);
    check("R9 irq", irq_o, 0);
    check("R9 data", rx_data_o, 0);
    check("R9 sclk", sclk_o, 1);
    rst_ni = 1'b1;
    clks(3);
    check("R6 slave idle ready", rdy_n_o, 0);

    // R1 R2 R3 R6 R8 slave mode, random bytes
    for (int n = 0; n < 20; n++) begin
      b  = (n == 0) ? 8'h01 : (n == 1) ? 8'h80 : 8'($urandom);
      ic = irq_cnt;
      send_slave(b);
      clks(2);
      check("R1 slave data", rx_data_o, exp_byte(b));
      check("R2 full set", full_o, 1);
      check("R2 one irq", irq_cnt - ic, 1);
      check("R6 busy when full", rdy_n_o, 1);
      check("R8 sclk_o idle in slave", sclk_o, 1);
      do_read();
      check("R3 read clears", full_o, 0);
      check("R6 ready after read", rdy_n_o, 0);
      check("R4 no overrun", ovr_o, 0);
    end

    // R4 R5 overrun
    a = 8'h3c; b = 8'hc5;
    send_slave(a);
    send_slave(b);
    clks(2);
    check("R4 ovr set", ovr_o, 1);
    check("R4 overwrite", rx_data_o, b);
    check("R4 still full", full_o, 1);
    do_read();
    check("R5 ovr survives read", ovr_o, 1);
    send_slave(8'h5a);
    do_read();
    check("R5 ovr survives frame", ovr_o, 1);
    ovr_clr_i = 1'b1; clks(1); ovr_clr_i = 1'b0; clks(1);
    check("R5 ovr cleared", ovr_o, 0);

    // R7 master mode
    for (int i = 0; i < 8; i++) m_bytes[i] = (i == 0) ? 8'hA5 : 8'($urandom);
    master_i = 1'b1;
    rdy_n_i  = 1'b1;
    clks(4);
    check("R6 master rdy_n_o", rdy_n_o, 1);
    m_falls = 0;
    clks(60);
    check("R7 no clock while not ready", m_falls, 0);
    check("R7 parked high", sclk_o, 1);
    for (int j = 0; j < 8; j++) begin
      ic = irq_cnt;
      rdy_n_i = 1'b0;
      wait_full();
      rdy_n_i = 1'b1;
      clks(4);
      check("R1 master data", rx_data_o, exp_byte(m_bytes[j]));
      check("R2 master irq", irq_cnt - ic, 1);
      check("R7 parked after ready high", sclk_o, 1);
      do_read();
      check("R3 master read clears", full_o, 0);
    end
    check("R4 master no ovr", ovr_o, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule